// File: doc/BRIEF.md
# Instruction Window with Operand Wakeup

This block is a circular instruction window that serves as reorder buffer and scheduler at once. Instructions enter in program order at the tail through a dispatch port. Each entry keeps three source-ready flags, a link to the producer of each pending source, two destination slots, a completion flag and a per-entry generation tag. A writeback broadcast names a producer by window index, generation tag and destination slot. Every waiting consumer linked to that triple sets its source flag. A ready vector marks every live, incomplete entry whose three sources are all ready, so that external issue logic can pick from it.

Completed entries leave in order from the head, at most one per cycle. A recovery request names a mispredicted branch by index and tag. In one cycle it removes every younger entry and bumps the generation tag of each removed slot, so later broadcasts aimed at the old occupants match nothing. A load or store also takes a slot in a small memory-side queue, here only an occupancy count. That slot is freed when its window entry commits or is squashed.

Top module: `instruction_window`

## Requirements
- R1: After reset the window is empty (`win_empty`=1, `win_full`=0), `ready_vec` is all zero, `cmt_valid` is 0, `disp_idx` is 0 with `disp_tag` 0, and `mem_used` is 0.
- R2: A dispatch is accepted when `disp_valid` and `disp_ready` are both high. It takes the entry at `disp_idx`, and that index steps by one modulo DEPTH after each accepted dispatch. `disp_tag` reports the current generation tag of that entry. With DEPTH entries occupied, `win_full` is 1 and `disp_ready` is 0.
- R3: A source whose `disp_src_pend` bit is 0 is ready at allocation. An entry with all three sources ready appears in `ready_vec` in the cycle after its dispatch.
- R4: A pending source links to producer index `disp_src_idx` (three IDXW-bit fields, source 0 in the low bits), destination slot `disp_src_slot`, and the producer's tag at dispatch. A broadcast sets the flag only when index, tag and slot all match. A mismatch in slot or tag leaves it clear.
- R5: A pending source is also ready at allocation in three cases: the producer entry is no longer live, the producer already broadcast that slot, or a matching broadcast arrives in the dispatch cycle.
- R6: A broadcast with `wb_last`=1 that matches an entry's index and tag marks it complete. A completed entry leaves `ready_vec`.
- R7: `cmt_valid` is high exactly when the head entry is complete. Commits follow allocation order, one per cycle, and stop at the first incomplete entry.
- R8: A recovery whose `rec_idx` names a live entry carrying tag `rec_tag` squashes every entry younger than it. The next dispatch then uses index `rec_idx`+1. A recovery naming a dead entry or a wrong tag is ignored.
- R9: Each squashed entry's generation tag is incremented. A broadcast carrying the old tag neither wakes consumers nor completes the new occupant.
- R10: `mem_used` counts live entries dispatched with `disp_mem`=1. Such a dispatch is refused while `mem_used` equals MEM_DEPTH. The count drops when a memory entry commits or is squashed.
- R11: While `rec_valid` is high, `disp_ready` is 0 and no dispatch is taken. A commit of the head still proceeds in that cycle.
- R12: When the window is empty, `cmt_valid` stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| disp_valid | input | 1 | Dispatch request |
| disp_src_pend | input | 3 | Per-source: producer still in flight |
| disp_src_idx | input | 3*IDXW | Producer window index per source |
| disp_src_slot | input | 3 | Producer destination slot per source |
| disp_dst_use | input | 2 | Destination slots used by this entry |
| disp_mem | input | 1 | Entry is a memory address computation |
| disp_ready | output | 1 | Dispatch can be accepted this cycle |
| disp_idx | output | IDXW | Index the next dispatch will take |
| disp_tag | output | TAGW | Generation tag of that index |
| wb_valid | input | 1 | Result broadcast |
| wb_idx | input | IDXW | Producer index of broadcast |
| wb_tag | input | TAGW | Producer tag of broadcast |
| wb_slot | input | 1 | Destination slot of broadcast |
| wb_last | input | 1 | Broadcast also completes the producer |
| ready_vec | output | DEPTH | Entries eligible for issue |
| cmt_valid | output | 1 | Head entry commits this cycle |
| cmt_idx | output | IDXW | Index of committing entry |
| cmt_mem | output | 1 | Committing entry holds a memory slot |
| rec_valid | input | 1 | Recovery request |
| rec_idx | input | IDXW | Index of mispredicted branch |
| rec_tag | input | TAGW | Tag of mispredicted branch |
| win_full | output | 1 | All entries occupied |
| win_empty | output | 1 | No entries occupied |
| mem_used | output | MUW | Occupied memory-queue slots |

## Verification
A corrupted wakeup link or generation tag shows up within a cycle as a `ready_vec` bit that stays clear after its matching broadcast, or that rises after a stale one. A head or occupancy error appears at the next commit, as a `cmt_idx` out of allocation order, or as a `disp_idx` that fails to return to the entry after the branch once a recovery is done. A wrong memory count shows as `mem_used` drifting from the number of live memory entries, or as a wrong accept or refuse decision for a memory dispatch.

// File: rtl/iw_pkg.sv
package iw_pkg;
   localparam int NSRC = 3;
   localparam int NDST = 2;
   localparam int SLW  = $clog2(NDST);

   function automatic int unsigned ones(input logic [63:0] v, input int unsigned n);
      int unsigned s;
      s = 0;
      for (int unsigned b = 0; b < n; b++) s += int'(v[b]);
      return s;
   endfunction
endpackage

// File: rtl/iw_entry.sv
module iw_entry
   import iw_pkg::*;
#(
   parameter int IDXW = 3,
   parameter int TAGW = 3,
   parameter logic [IDXW-1:0] SELF = '0
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      alloc,
   input  logic                      squash,
   input  logic                      retire,
   input  logic [NSRC-1:0]           a_rdy,
   input  logic [NSRC-1:0][IDXW-1:0] a_lidx,
   input  logic [NSRC-1:0][TAGW-1:0] a_ltag,
   input  logic [NSRC-1:0][SLW-1:0]  a_lslot,
   input  logic [NDST-1:0]           a_dst_use,
   input  logic                      a_mem,
   input  logic                      wb_valid,
   input  logic [IDXW-1:0]           wb_idx,
   input  logic [TAGW-1:0]           wb_tag,
   input  logic [SLW-1:0]            wb_slot,
   input  logic                      wb_last,
   output logic                      live,
   output logic [TAGW-1:0]           gen,
   output logic                      eligible,
   output logic                      complete,
   output logic [NDST-1:0]           dst_done,
   output logic                      is_mem
);
   logic [NSRC-1:0]           src_ok;
   logic [NSRC-1:0][IDXW-1:0] lnk_idx;
   logic [NSRC-1:0][TAGW-1:0] lnk_tag;
   logic [NSRC-1:0][SLW-1:0]  lnk_slot;
   logic [NSRC-1:0]           hit_src;
   logic                      hit_self;

   always_comb begin
      for (int k = 0; k < NSRC; k++)
         hit_src[k] = wb_valid && (lnk_idx[k] == wb_idx) &&
                      (lnk_tag[k] == wb_tag) && (lnk_slot[k] == wb_slot);
   end

   assign hit_self = wb_valid && (wb_idx == SELF) && (wb_tag == gen);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         live     <= 1'b0;
         gen      <= '0;
         src_ok   <= '0;
         lnk_idx  <= '0;
         lnk_tag  <= '0;
         lnk_slot <= '0;
         complete <= 1'b0;
         dst_done <= '0;
         is_mem   <= 1'b0;
      end else if (squash) begin
         live     <= 1'b0;
         gen      <= gen + 1'b1;
         complete <= 1'b0;
         is_mem   <= 1'b0;
      end else if (retire) begin
         live     <= 1'b0;
         complete <= 1'b0;
         is_mem   <= 1'b0;
      end else if (alloc) begin
         live     <= 1'b1;
         src_ok   <= a_rdy;
         lnk_idx  <= a_lidx;
         lnk_tag  <= a_ltag;
         lnk_slot <= a_lslot;
         complete <= 1'b0;
         dst_done <= ~a_dst_use;
         is_mem   <= a_mem;
      end else if (live) begin
         src_ok <= src_ok | hit_src;
         if (hit_self) begin
            dst_done[wb_slot] <= 1'b1;
            if (wb_last) complete <= 1'b1;
         end
      end
   end

   assign eligible = live && (&src_ok) && !complete;
endmodule

// File: rtl/iw_ptr.sv
module iw_ptr #(
   parameter int DEPTH = 8,
   localparam int IDXW = $clog2(DEPTH),
   localparam int CNTW = $clog2(DEPTH + 1)
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            disp_fire,
   input  logic            cmt_fire,
   input  logic            rec_fire,
   input  logic [IDXW-1:0] rec_idx,
   input  logic [IDXW-1:0] rec_age,
   output logic [IDXW-1:0] head,
   output logic [IDXW-1:0] tail,
   output logic            full,
   output logic            empty
);
   logic [CNTW-1:0] count;
   logic [CNTW-1:0] kept;

   assign kept  = CNTW'(rec_age) + CNTW'(1);
   assign full  = (count == CNTW'(DEPTH));
   assign empty = (count == '0);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         head  <= '0;
         tail  <= '0;
         count <= '0;
      end else begin
         head <= head + IDXW'(cmt_fire);
         if (rec_fire) begin
            tail  <= rec_idx + 1'b1;
            count <= kept - CNTW'(cmt_fire);
         end else begin
            tail  <= tail + IDXW'(disp_fire);
            count <= count + CNTW'(disp_fire) - CNTW'(cmt_fire);
         end
      end
   end
endmodule

// File: rtl/iw_memq.sv
module iw_memq
   import iw_pkg::*;
#(
   parameter int DEPTH     = 8,
   parameter int MEM_DEPTH = 4,
   localparam int MUW = $clog2(MEM_DEPTH + 1),
   localparam int SW  = $clog2(DEPTH + 1)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             take,
   input  logic             give,
   input  logic [DEPTH-1:0] drop_vec,
   output logic [MUW-1:0]   used,
   output logic             mfull
);
   logic [SW-1:0] dropped;
   logic [SW-1:0] nxt;

   assign dropped = SW'(ones(64'(drop_vec), DEPTH));
   assign nxt     = SW'(used) + SW'(take) - SW'(give) - dropped;
   assign mfull   = (used == MUW'(MEM_DEPTH));

   always_ff @(posedge clk) begin
      if (!rst_n) used <= '0;
      else        used <= MUW'(nxt);
   end
endmodule

// File: rtl/instruction_window.sv
module instruction_window
   import iw_pkg::*;
#(
   parameter int DEPTH     = 8,
   parameter int TAGW      = 3,
   parameter int MEM_DEPTH = 4,
   parameter bit BYPASS    = 1'b1,
   localparam int IDXW = $clog2(DEPTH),
   localparam int MUW  = $clog2(MEM_DEPTH + 1)
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 disp_valid,
   input  logic [NSRC-1:0]      disp_src_pend,
   input  logic [NSRC*IDXW-1:0] disp_src_idx,
   input  logic [NSRC-1:0]      disp_src_slot,
   input  logic [NDST-1:0]      disp_dst_use,
   input  logic                 disp_mem,
   output logic                 disp_ready,
   output logic [IDXW-1:0]      disp_idx,
   output logic [TAGW-1:0]      disp_tag,
   input  logic                 wb_valid,
   input  logic [IDXW-1:0]      wb_idx,
   input  logic [TAGW-1:0]      wb_tag,
   input  logic                 wb_slot,
   input  logic                 wb_last,
   output logic [DEPTH-1:0]     ready_vec,
   output logic                 cmt_valid,
   output logic [IDXW-1:0]      cmt_idx,
   output logic                 cmt_mem,
   input  logic                 rec_valid,
   input  logic [IDXW-1:0]      rec_idx,
   input  logic [TAGW-1:0]      rec_tag,
   output logic                 win_full,
   output logic                 win_empty,
   output logic [MUW-1:0]       mem_used
);
   logic [DEPTH-1:0]      e_live, e_done, e_mem, e_elig, kill;
   logic [TAGW-1:0]       e_gen [DEPTH];
   logic [NDST-1:0]       e_dsd [DEPTH];
   logic [IDXW-1:0]       head, tail, rec_age;
   logic                  mem_full, disp_fire, cmt_fire, rec_fire;
   logic [NSRC-1:0]       a_rdy;
   logic [NSRC-1:0][IDXW-1:0] a_lidx;
   logic [NSRC-1:0][TAGW-1:0] a_ltag;
   logic [NSRC-1:0][SLW-1:0]  a_lslot;

   assign disp_ready = !win_full && !rec_valid && !(disp_mem && mem_full);
   assign disp_fire  = disp_valid && disp_ready;
   assign cmt_fire   = !win_empty && e_done[head];
   assign rec_fire   = rec_valid && e_live[rec_idx] && (e_gen[rec_idx] == rec_tag);
   assign rec_age    = rec_idx - head;

   assign disp_idx  = tail;
   assign disp_tag  = e_gen[tail];
   assign ready_vec = e_elig;
   assign cmt_valid = cmt_fire;
   assign cmt_idx   = head;
   assign cmt_mem   = e_mem[head];

   // producer lookup at dispatch, one per source
   for (genvar k = 0; k < NSRC; k++) begin : g_src
      logic [IDXW-1:0] pi;
      logic            sl;
      logic            byp;
      assign pi = disp_src_idx[k*IDXW +: IDXW];
      assign sl = disp_src_slot[k];
      if (BYPASS) begin : g_byp
         assign byp = wb_valid && (wb_idx == pi) && (wb_tag == e_gen[pi]) && (wb_slot == sl);
      end else begin : g_nobyp
         assign byp = 1'b0;
      end
      assign a_rdy[k]   = !disp_src_pend[k] || !e_live[pi] || e_dsd[pi][sl] || byp;
      assign a_lidx[k]  = pi;
      assign a_ltag[k]  = e_gen[pi];
      assign a_lslot[k] = sl;
   end

   // window slots
   for (genvar i = 0; i < DEPTH; i++) begin : g_ent
      logic [IDXW-1:0] age;
      assign age     = IDXW'(i) - head;
      assign kill[i] = rec_fire && e_live[i] && (age > rec_age);

      iw_entry #(.IDXW(IDXW), .TAGW(TAGW), .SELF(IDXW'(i))) u_ent (
         .clk      (clk),
         .rst_n    (rst_n),
         .alloc    (disp_fire && (tail == IDXW'(i))),
         .squash   (kill[i]),
         .retire   (cmt_fire && (head == IDXW'(i))),
         .a_rdy    (a_rdy),
         .a_lidx   (a_lidx),
         .a_ltag   (a_ltag),
         .a_lslot  (a_lslot),
         .a_dst_use(disp_dst_use),
         .a_mem    (disp_mem),
         .wb_valid (wb_valid),
         .wb_idx   (wb_idx),
         .wb_tag   (wb_tag),
         .wb_slot  (wb_slot),
         .wb_last  (wb_last),
         .live     (e_live[i]),
         .gen      (e_gen[i]),
         .eligible (e_elig[i]),
         .complete (e_done[i]),
         .dst_done (e_dsd[i]),
         .is_mem   (e_mem[i])
      );
   end

   iw_ptr #(.DEPTH(DEPTH)) u_ptr (
      .clk      (clk),
      .rst_n    (rst_n),
      .disp_fire(disp_fire),
      .cmt_fire (cmt_fire),
      .rec_fire (rec_fire),
      .rec_idx  (rec_idx),
      .rec_age  (rec_age),
      .head     (head),
      .tail     (tail),
      .full     (win_full),
      .empty    (win_empty)
   );

   iw_memq #(.DEPTH(DEPTH), .MEM_DEPTH(MEM_DEPTH)) u_memq (
      .clk     (clk),
      .rst_n   (rst_n),
      .take    (disp_fire && disp_mem),
      .give    (cmt_fire && e_mem[head]),
      .drop_vec(kill & e_mem),
      .used    (mem_used),
      .mfull   (mem_full)
   );
endmodule

// File: rtl/iw_checker.sv
module iw_checker #(
   parameter int DEPTH     = 8,
   parameter int TAGW      = 3,
   parameter int MEM_DEPTH = 4,
   localparam int IDXW = $clog2(DEPTH),
   localparam int MUW  = $clog2(MEM_DEPTH + 1)
) (
   input logic             clk,
   input logic             rst_n,
   input logic             disp_valid,
   input logic             disp_ready,
   input logic [IDXW-1:0]  disp_idx,
   input logic             win_full,
   input logic             win_empty,
   input logic             cmt_valid,
   input logic [IDXW-1:0]  cmt_idx,
   input logic [DEPTH-1:0] ready_vec,
   input logic             rec_valid,
   input logic             rec_fire,
   input logic [IDXW-1:0]  rec_idx,
   input logic [MUW-1:0]   mem_used
);
   initial begin
      assert (DEPTH >= 2 && (DEPTH & (DEPTH - 1)) == 0) else $error("DEPTH must be a power of two");
      assert (MEM_DEPTH >= 1 && MEM_DEPTH <= DEPTH) else $error("MEM_DEPTH out of range");
      assert (TAGW >= 1) else $error("TAGW must be positive");
   end

   assert_full_blocks_R2: assert property (@(posedge clk) disable iff (!rst_n)
      win_full |-> !disp_ready);

   assert_disp_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (disp_valid && disp_ready) |=> (disp_idx == IDXW'($past(disp_idx) + 1'b1)));

   assert_done_not_ready_R6: assert property (@(posedge clk) disable iff (!rst_n)
      cmt_valid |-> !ready_vec[cmt_idx]);

   assert_commit_order_R7: assert property (@(posedge clk) disable iff (!rst_n)
      cmt_valid |=> (!cmt_valid || cmt_idx == IDXW'($past(cmt_idx) + 1'b1)));

   assert_recover_tail_R8: assert property (@(posedge clk) disable iff (!rst_n)
      rec_fire |=> (disp_idx == IDXW'($past(rec_idx) + 1'b1)));

   assert_mem_bound_R10: assert property (@(posedge clk) disable iff (!rst_n)
      mem_used <= MUW'(MEM_DEPTH));

   assert_rec_blocks_disp_R11: assert property (@(posedge clk) disable iff (!rst_n)
      rec_valid |-> !disp_ready);

   assert_empty_no_commit_R12: assert property (@(posedge clk) disable iff (!rst_n)
      win_empty |-> !cmt_valid);
endmodule

bind instruction_window iw_checker #(.DEPTH(DEPTH), .TAGW(TAGW), .MEM_DEPTH(MEM_DEPTH)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .disp_valid(disp_valid),
   .disp_ready(disp_ready),
   .disp_idx  (disp_idx),
   .win_full  (win_full),
   .win_empty (win_empty),
   .cmt_valid (cmt_valid),
   .cmt_idx   (cmt_idx),
   .ready_vec (ready_vec),
   .rec_valid (rec_valid),
   .rec_fire  (rec_fire),
   .rec_idx   (rec_idx),
   .mem_used  (mem_used)
);

// File: tb/tb_instruction_window.sv
module tb_instruction_window;
   localparam int DEPTH = 8, TAGW = 3, MEMD = 4, IDXW = 3, MUW = 3;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #2.5 clk = ~clk;

   logic            disp_valid, disp_mem, disp_ready;
   logic [2:0]      disp_src_pend, disp_src_slot;
   logic [8:0]      disp_src_idx;
   logic [1:0]      disp_dst_use;
   logic [IDXW-1:0] disp_idx, wb_idx, cmt_idx, rec_idx;
   logic [TAGW-1:0] disp_tag, wb_tag, rec_tag;
   logic            wb_valid, wb_slot, wb_last, cmt_valid, cmt_mem, rec_valid;
   logic [DEPTH-1:0] ready_vec;
   logic            win_full, win_empty;
   logic [MUW-1:0]  mem_used;

   instruction_window #(.DEPTH(DEPTH), .TAGW(TAGW), .MEM_DEPTH(MEMD)) dut (
      .clk(clk), .rst_n(rst_n),
      .disp_valid(disp_valid), .disp_src_pend(disp_src_pend), .disp_src_idx(disp_src_idx),
      .disp_src_slot(disp_src_slot), .disp_dst_use(disp_dst_use), .disp_mem(disp_mem),
      .disp_ready(disp_ready), .disp_idx(disp_idx), .disp_tag(disp_tag),
      .wb_valid(wb_valid), .wb_idx(wb_idx), .wb_tag(wb_tag), .wb_slot(wb_slot), .wb_last(wb_last),
      .ready_vec(ready_vec), .cmt_valid(cmt_valid), .cmt_idx(cmt_idx), .cmt_mem(cmt_mem),
      .rec_valid(rec_valid), .rec_idx(rec_idx), .rec_tag(rec_tag),
      .win_full(win_full), .win_empty(win_empty), .mem_used(mem_used)
   );

   int checks = 0, errors = 0;
   bit finished = 0;
   logic [3:0] expq[$];     // {mem, idx} in allocation order
   logic [TAGW-1:0] tg [DEPTH];

   task automatic chk(input string req, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic finish_run();
      if (!finished) begin
         finished = 1;
         $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   endtask

   task automatic clear_in();
      disp_valid = 0; disp_src_pend = 0; disp_src_idx = 0; disp_src_slot = 0;
      disp_dst_use = 0; disp_mem = 0; wb_valid = 0; wb_idx = 0; wb_tag = 0;
      wb_slot = 0; wb_last = 0; rec_valid = 0; rec_idx = 0; rec_tag = 0;
   endtask

   task automatic tick();
      @(negedge clk);
      clear_in();
   endtask

   task automatic set_wb(input int i, input int t, input bit s, input bit l);
      wb_valid = 1; wb_idx = IDXW'(i); wb_tag = TAGW'(t); wb_slot = s; wb_last = l;
   endtask

   task automatic disp(input logic [2:0] pend, input int p0, input int p1, input int p2,
                       input logic [2:0] sl, input logic [1:0] du, input bit m, output bit acc);
      disp_valid = 1; disp_src_pend = pend;
      disp_src_idx = {3'(p2), 3'(p1), 3'(p0)};
      disp_src_slot = sl; disp_dst_use = du; disp_mem = m;
      #1;
      acc = disp_ready;
      if (acc) expq.push_back({m, disp_idx});
      tick();
   endtask

   // scoreboard monitor: every commit must match the oldest expected entry
   always @(negedge clk) begin
      if (rst_n && cmt_valid) begin
         if (expq.size() == 0) chk("R7 unexpected commit", 1, 0);
         else begin
            logic [3:0] e;
            e = expq.pop_front();
            chk("R7 commit index order", cmt_idx, e[2:0]);
            chk("R10 commit memory flag", cmt_mem, e[3]);
         end
      end
   end

   initial begin
      repeat (20000) @(posedge clk);
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
   end

   initial begin
      bit acc;
      clear_in();
      for (int i = 0; i < DEPTH; i++) tg[i] = '0;
      repeat (3) @(negedge clk);
      rst_n = 1;
      // R1 reset state
      chk("R1 empty", win_empty, 1); chk("R1 full", win_full, 0);
      chk("R1 ready_vec", ready_vec, 0); chk("R1 cmt_valid", cmt_valid, 0);
      chk("R1 disp_idx", disp_idx, 0); chk("R1 disp_tag", disp_tag, 0);
      chk("R1 mem_used", mem_used, 0);

      // A at 0: no pending sources
      disp(3'b000, 0, 0, 0, 3'b000, 2'b01, 0, acc);
      chk("R2 accept A", acc, 1); chk("R3 A ready after dispatch", ready_vec, 8'h01);
      chk("R2 disp_idx advances", disp_idx, 1);
      // B at 1: src0 waits on A slot0
      disp(3'b001, 0, 0, 0, 3'b000, 2'b11, 0, acc);
      chk("R4 B waits", ready_vec, 8'h01);
      set_wb(0, 0, 1, 0); tick();
      chk("R4 wrong slot ignored", ready_vec, 8'h01);
      set_wb(0, 1, 0, 1); tick();
      chk("R4 wrong tag ignored", ready_vec, 8'h01); chk("R6 wrong tag no complete", cmt_valid, 0);
      set_wb(0, 0, 0, 1); tick();
      chk("R4 B woken, R6 A leaves ready", ready_vec, 8'h02);
      chk("R6 A complete commits", cmt_valid, 1);
      // C at 2 waits on B slot1 (A commits on this edge)
      disp(3'b010, 0, 1, 0, 3'b010, 2'b01, 0, acc);
      chk("R4 C waits", ready_vec, 8'h02); chk("R7 stop at incomplete head", cmt_valid, 0);
      // D at 3 waits on dead entry 0
      disp(3'b100, 0, 0, 0, 3'b000, 2'b01, 0, acc);
      chk("R5 dead producer ready", ready_vec, 8'h0A);
      // E at 4 waits on B slot1 while B broadcasts slot1
      set_wb(1, 0, 1, 0);
      disp(3'b001, 1, 0, 0, 3'b001, 2'b01, 0, acc);
      chk("R5 same-cycle broadcast", ready_vec, 8'h1E);
      // F at 5 waits on B slot1, already broadcast
      disp(3'b001, 1, 0, 0, 3'b001, 2'b01, 0, acc);
      chk("R5 already broadcast", ready_vec, 8'h3E);
      set_wb(3, 0, 0, 1); tick();
      chk("R6 D complete", ready_vec, 8'h36); chk("R7 head 1 incomplete", cmt_valid, 0);
      set_wb(1, 0, 0, 1); tick();
      chk("R7 head commits", cmt_valid, 1);
      set_wb(2, 0, 0, 1); tick();
      repeat (3) tick();
      chk("R7 stop at entry 4", cmt_valid, 0);

      // memory ops G(6) H(7) I(0)
      disp(3'b000, 0, 0, 0, 3'b000, 2'b01, 1, acc);
      disp(3'b000, 0, 0, 0, 3'b000, 2'b01, 1, acc);
      disp(3'b000, 0, 0, 0, 3'b000, 2'b01, 1, acc);
      chk("R2 wraps", disp_idx, 1); chk("R10 mem count", mem_used, 3);
      rec_valid = 1; rec_idx = 6; rec_tag = 3; tick();
      chk("R8 wrong tag ignored", disp_idx, 1); chk("R8 wrong tag mem", mem_used, 3);
      rec_valid = 1; rec_idx = 2; rec_tag = 0; tick();
      chk("R8 dead entry ignored", disp_idx, 1);
      set_wb(4, 0, 0, 1); tick();     // entry 4 commits during the recovery cycle
      rec_valid = 1; rec_idx = 5; rec_tag = 0; disp_valid = 1;
      #1; chk("R11 dispatch blocked in recovery", disp_ready, 0);
      tick();
      for (int n = 0; n < 3; n++) void'(expq.pop_back());
      tg[6]++; tg[7]++; tg[0]++;
      chk("R8 tail after branch", disp_idx, 6);
      chk("R9 tag bumped", disp_tag, tg[6]);
      chk("R10 squash frees mem", mem_used, 0);
      chk("R8 squashed not ready", ready_vec & 8'hC1, 0);

      // J at 6 with new tag; stale broadcast must not complete it
      disp(3'b000, 0, 0, 0, 3'b000, 2'b01, 0, acc);
      set_wb(6, 0, 0, 1); tick();
      chk("R9 stale broadcast ignored", ready_vec[6], 1);
      // fill memory queue
      for (int n = 0; n < 4; n++) disp(3'b000, 0, 0, 0, 3'b000, 2'b01, 1, acc);
      chk("R10 mem full count", mem_used, 4);
      disp(3'b000, 0, 0, 0, 3'b000, 2'b01, 1, acc);
      chk("R10 mem dispatch refused", acc, 0);
      disp(3'b000, 0, 0, 0, 3'b000, 2'b01, 0, acc);
      chk("R10 plain dispatch accepted", acc, 1);
      disp(3'b000, 0, 0, 0, 3'b000, 2'b01, 0, acc);
      chk("R2 last slot accepted", acc, 1);
      chk("R2 full flag", win_full, 1);
      disp(3'b000, 0, 0, 0, 3'b000, 2'b01, 0, acc);
      chk("R2 full refuses", acc, 0);

      // drain in order
      for (int n = 0; n < DEPTH; n++) begin
         int i;
         i = (5 + n) % DEPTH;
         set_wb(i, tg[i], 0, 1); tick();
      end
      repeat (4) tick();
      chk("R12 empty after drain", win_empty, 1);
      chk("R12 no commit when empty", cmt_valid, 0);
      chk("R10 commits free mem", mem_used, 0);
      chk("R7 all expected commits seen", expq.size(), 0);
      finish_run();
   end
endmodule